// File: doc/BRIEF.md
# Prescaled 16-bit Timer/Counter

The block is a 16-bit up-counter for a peripheral bus. It counts one of two sources: a fixed tick at one quarter of the system clock, or rising edges on an external clock pin. The selected source goes through a prescaler that divides by 1, 2, 4 or 8 before it reaches the counter. External edges can take a two-flop synchronizer path or a shorter single-sample path. An enable bit stops all counting when it is low.

Software reaches the block over an 8-bit register bus. The high byte of the count sits behind a holding register, so 16-bit reads and writes are atomic. Reading the low byte captures the high byte at the same moment. A write to the high byte is staged and takes effect together with the next low-byte write. When the count rolls over from 0xFFFF, a sticky overflow flag is set, and software clears it by writing 1 to it. A pulse on the trigger input forces the count to zero.

Top module: `tmr16_periph`

## Requirements
- R1: The control register at address 2 resets to 0x00 and reads back only its defined fields: bit 0 is the enable, bit 1 the source (0 = internal tick, 1 = external pin), bit 2 the asynchronous path select, and bits 5:4 the prescale exponent. All other bits read 0.
- R2: With the internal source and prescale exponent 0, the count advances exactly once every 4 system clocks.
- R3: A prescale exponent of k divides the selected source by 2^k, for k from 0 to 3.
- R4: With the external source, each rising edge of `ext_clk_i` counts as one source event, however long the input stays high.
- R5: With prescale 1, the incremented count is visible after the third rising clock edge at which `ext_clk_i` is sampled high on the synchronized path (bit 2 = 0), and after the second such edge on the asynchronous path (bit 2 = 1).
- R6: An increment from 0xFFFF wraps the count to 0x0000 and sets the overflow flag, which reads as bit 0 at address 3 and drives `ovf_flag_o`.
- R7: Writing address 3 with data bit 0 = 1 clears the flag, and a write with bit 0 = 0 leaves it unchanged. A clearing write on the same edge as an overflow leaves the flag set.
- R8: `evt_clr_i` high at a clock edge sets the count to zero. It takes priority over a low-byte write and over an increment on the same edge.
- R9: Reading address 0 returns the live low byte and copies the live high byte into the holding register on that edge. Reading address 1 returns the holding register.
- R10: Writing address 1 loads only the holding register. Writing address 0 loads the counter with {holding register, data} and clears the prescaler.
- R11: While the enable bit is 0, the count changes only through a low-byte write or the trigger input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_clk_i | input | 1 | External count source |
| evt_clr_i | input | 1 | Trigger that forces the count to zero |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe (causes the high-byte capture side effect) |
| bus_addr_i | input | 2 | Register address: 0 count low, 1 count high buffer, 2 control, 3 status |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed register (combinational) |
| ovf_flag_o | output | 1 | Sticky overflow flag |

## Verification
The flag logic has two functions that can fall on the same edge: setting the flag on an overflow and clearing it through a software write. The bench produces the collision in a repeatable way. It preloads 0xFFFF, selects the asynchronous external path so the increment edge is known, and places the clearing write on exactly that edge. It then expects the flag to stay set and the count to read zero. A second collision drives the trigger together with a low-byte write and expects zero.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam logic [1:0] ADDR_CNT_LO = 2'd0;
  localparam logic [1:0] ADDR_CNT_HI = 2'd1;
  localparam logic [1:0] ADDR_CTRL   = 2'd2;
  localparam logic [1:0] ADDR_STAT   = 2'd3;

  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_SRC_BIT   = 1;
  localparam int CTRL_ASYNC_BIT = 2;
  localparam int CTRL_PS_LSB    = 4;
  localparam int PS_W           = 2;

  typedef struct packed {
    logic [PS_W-1:0] ps;
    logic            async_m;
    logic            src_ext;
    logic            en;
  } tmr_ctrl_t;
endpackage

// File: rtl/tmr16_src.sv
module tmr16_src #(
  parameter int DIV_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_i,
  input  logic en_i,
  input  logic src_ext_i,
  input  logic async_i,
  output logic tick_o
);
  logic [DIV_W-1:0]     div_q;
  logic [SYNC_STAGES:0] sh_q;
  logic                 int_tick, edge_sync, edge_async, ext_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      sh_q  <= '0;
    end else begin
      div_q <= div_q + 1'b1;
      sh_q  <= {sh_q[SYNC_STAGES-1:0], ext_i};
    end
  end

  assign int_tick   = &div_q;
  // full synchronizer chain vs. single sample flop
  assign edge_sync  = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
  assign edge_async = sh_q[0] & ~sh_q[1];
  assign ext_tick   = async_i ? edge_async : edge_sync;
  assign tick_o     = en_i & (src_ext_i ? ext_tick : int_tick);
endmodule

// File: rtl/tmr16_presc.sv
module tmr16_presc #(
  parameter int PS_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic [PS_W-1:0] ps_i,
  input  logic            tick_i,
  output logic            tick_o
);
  localparam int PC_W = (1 << PS_W) - 1;

  logic [PC_W-1:0] pc_q, mask;

  for (genvar g = 0; g < PC_W; g++) begin : g_mask
    assign mask[g] = (PS_W'(g) < ps_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pc_q <= '0;
    else if (clr_i)  pc_q <= '0;
    else if (tick_i) pc_q <= pc_q + 1'b1;
  end

  assign tick_o = tick_i & ((pc_q & mask) == mask);

  a_r3_tick_subset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> tick_i);
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
  import tmr16_pkg::*;
#(
  parameter int BUS_W = 8,
  localparam int CNT_W = 2 * BUS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             evt_clr_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [1:0]       addr_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [CNT_W-1:0] count_o,
  output logic [BUS_W-1:0] hbuf_o,
  output logic             flag_o,
  output logic             ld_o
);
  logic [CNT_W-1:0] count_q, count_d;
  logic [BUS_W-1:0] hbuf_q;
  logic             flag_q, ld, wr_hi, rd_lo, clr_flag, ovf;

  assign ld       = wr_i && (addr_i == ADDR_CNT_LO);
  assign wr_hi    = wr_i && (addr_i == ADDR_CNT_HI);
  assign rd_lo    = rd_i && !wr_i && (addr_i == ADDR_CNT_LO);
  assign clr_flag = wr_i && (addr_i == ADDR_STAT) && wdata_i[0];
  assign ovf      = inc_i && (&count_q) && !evt_clr_i && !ld;

  always_comb begin
    count_d = count_q;
    if (evt_clr_i)  count_d = '0;
    else if (ld)    count_d = {hbuf_q, wdata_i};
    else if (inc_i) count_d = count_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      hbuf_q  <= '0;
      flag_q  <= 1'b0;
    end else begin
      count_q <= count_d;
      if (wr_hi)      hbuf_q <= wdata_i;
      else if (rd_lo) hbuf_q <= count_q[CNT_W-1:BUS_W];
      if (ovf)           flag_q <= 1'b1;
      else if (clr_flag) flag_q <= 1'b0;
    end
  end

  assign count_o = count_q;
  assign hbuf_o  = hbuf_q;
  assign flag_o  = flag_q;
  assign ld_o    = ld;

  a_r8_evt_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_clr_i |=> (count_q == '0));
  a_r6_ovf_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && (&count_q) && !evt_clr_i && !wr_i) |=> (flag_q && count_q == '0));
  a_r7_collision_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf && clr_flag) |=> flag_q);
  a_r7_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_flag && !inc_i) |=> !flag_q);
  a_r10_hbuf_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi |=> (hbuf_q == $past(wdata_i)));
endmodule

// File: rtl/tmr16_periph.sv
module tmr16_periph
  import tmr16_pkg::*;
#(
  parameter int BUS_W       = 8,
  parameter int DIV_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_clk_i,
  input  logic             evt_clr_i,
  input  logic             bus_wr_i,
  input  logic             bus_rd_i,
  input  logic [1:0]       bus_addr_i,
  input  logic [BUS_W-1:0] bus_wdata_i,
  output logic [BUS_W-1:0] bus_rdata_o,
  output logic             ovf_flag_o
);
  localparam int CNT_W = 2 * BUS_W;

  tmr_ctrl_t        ctrl_q;
  logic             src_tick, inc, ld;
  logic [CNT_W-1:0] count;
  logic [BUS_W-1:0] hbuf;
  logic             flag;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (bus_wr_i && bus_addr_i == ADDR_CTRL) begin
      ctrl_q.en      <= bus_wdata_i[CTRL_EN_BIT];
      ctrl_q.src_ext <= bus_wdata_i[CTRL_SRC_BIT];
      ctrl_q.async_m <= bus_wdata_i[CTRL_ASYNC_BIT];
      ctrl_q.ps      <= bus_wdata_i[CTRL_PS_LSB +: PS_W];
    end
  end

  tmr16_src #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk_i, .rst_ni,
    .ext_i     (ext_clk_i),
    .en_i      (ctrl_q.en),
    .src_ext_i (ctrl_q.src_ext),
    .async_i   (ctrl_q.async_m),
    .tick_o    (src_tick)
  );

  tmr16_presc #(.PS_W(PS_W)) u_presc (
    .clk_i, .rst_ni,
    .clr_i  (ld),
    .ps_i   (ctrl_q.ps),
    .tick_i (src_tick),
    .tick_o (inc)
  );

  tmr16_core #(.BUS_W(BUS_W)) u_core (
    .clk_i, .rst_ni,
    .inc_i     (inc),
    .evt_clr_i (evt_clr_i),
    .wr_i      (bus_wr_i),
    .rd_i      (bus_rd_i),
    .addr_i    (bus_addr_i),
    .wdata_i   (bus_wdata_i),
    .count_o   (count),
    .hbuf_o    (hbuf),
    .flag_o    (flag),
    .ld_o      (ld)
  );

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      ADDR_CNT_LO: bus_rdata_o = count[BUS_W-1:0];
      ADDR_CNT_HI: bus_rdata_o = hbuf;
      ADDR_CTRL: begin
        bus_rdata_o[CTRL_EN_BIT]            = ctrl_q.en;
        bus_rdata_o[CTRL_SRC_BIT]           = ctrl_q.src_ext;
        bus_rdata_o[CTRL_ASYNC_BIT]         = ctrl_q.async_m;
        bus_rdata_o[CTRL_PS_LSB +: PS_W]    = ctrl_q.ps;
      end
      default: bus_rdata_o[0] = flag;
    endcase
  end

  assign ovf_flag_o = flag;

  a_r11_disabled_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.en && !evt_clr_i && !ld) |=> $stable(count));
endmodule

// File: tb/tmr16_periph_tb_top.sv
module tmr16_periph_tb_top;
  logic       clk = 1'b0, rst_n = 1'b0, ext = 1'b0, evt = 1'b0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  wire  [7:0] rdata;
  wire        flag;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  tmr16_periph dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ext_clk_i(ext), .evt_clr_i(evt),
    .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .ovf_flag_o(flag)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; #1 v = rdata;
  endtask

  task automatic snap(output logic [15:0] v);
    @(negedge clk); rd = 1'b1; addr = 2'd0; #1 v[7:0] = rdata;
    @(negedge clk); rd = 1'b0; addr = 2'd1; #1 v[15:8] = rdata;
  endtask

  task automatic load(input logic [15:0] v);
    bus_wr(2'd1, v[15:8]);
    bus_wr(2'd0, v[7:0]);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext = 1'b1;
      repeat (2) @(negedge clk);
      ext = 1'b0;
      repeat (2) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v; logic [15:0] c;
    peek(2'd2, v); chk("R1", "ctrl after reset", v, 8'h00);
    peek(2'd3, v); chk("R6", "status after reset", v, 8'h00);
    snap(c);       chk("R1", "count after reset", c, 16'h0000);
  endtask

  task automatic t_ctrl_readback();
    logic [7:0] v;
    bus_wr(2'd2, 8'hFE); peek(2'd2, v); chk("R1", "ctrl readback FE", v, 8'h36);
    bus_wr(2'd0 + 2'd2, 8'h00); peek(2'd2, v); chk("R1", "ctrl readback 00", v, 8'h00);
  endtask

  task automatic t_write_staging();
    logic [15:0] c;
    load(16'h0042);
    bus_wr(2'd1, 8'h12);
    snap(c); chk("R10", "high write leaves counter", c, 16'h0042);
    bus_wr(2'd1, 8'h12); bus_wr(2'd0, 8'h34);
    snap(c); chk("R10", "low write loads both bytes", c, 16'h1234);
  endtask

  task automatic t_disabled();
    logic [15:0] c;
    bus_wr(2'd2, 8'h00); load(16'h0042);
    repeat (50) @(negedge clk);
    snap(c); chk("R11", "internal source disabled", c, 16'h0042);
    bus_wr(2'd2, 8'h02); pulses(4);
    snap(c); chk("R11", "external source disabled", c, 16'h0042);
    bus_wr(2'd2, 8'h00);
  endtask

  task automatic t_internal_rate(input logic [1:0] ps, input int k);
    logic [15:0] a, b;
    bus_wr(2'd2, 8'h00); load(16'h0000);
    bus_wr(2'd2, {2'b00, ps, 4'h1});
    snap(a);
    repeat (k - 2) @(negedge clk);
    snap(b);
    bus_wr(2'd2, 8'h00);
    chk(ps == 0 ? "R2" : "R3", $sformatf("internal ps=%0d delta", ps), b - a, k / (4 << ps));
  endtask

  task automatic t_external_count();
    logic [15:0] c;
    bus_wr(2'd2, 8'h00); load(16'h0000);
    bus_wr(2'd2, 8'h23); pulses(12);
    snap(c); chk("R4", "sync ext 12 edges div4", c, 16'h0003);
    bus_wr(2'd2, 8'h00); load(16'h0000);
    bus_wr(2'd2, 8'h17); pulses(6);
    snap(c); chk("R3", "async ext 6 edges div2", c, 16'h0003);
    bus_wr(2'd2, 8'h00);
  endtask

  task automatic t_presc_clear();
    logic [15:0] c;
    bus_wr(2'd2, 8'h00); load(16'h0000);
    bus_wr(2'd2, 8'h23); pulses(3);
    load(16'h0000); pulses(2);
    snap(c); chk("R10", "low write clears prescaler", c, 16'h0000);
    bus_wr(2'd2, 8'h00);
  endtask

  task automatic t_latency(input bit async_m);
    string r = "R5";
    bus_wr(2'd2, 8'h00); load(16'h0000);
    bus_wr(2'd2, async_m ? 8'h07 : 8'h03);
    repeat (4) @(negedge clk);
    @(negedge clk); ext = 1'b1; addr = 2'd0;
    @(negedge clk); #1 chk(r, "after 1st edge", rdata, 0);
    @(negedge clk); #1 chk(r, async_m ? "async after 2nd edge" : "sync after 2nd edge", rdata, async_m ? 1 : 0);
    @(negedge clk); #1 chk(r, "after 3rd edge", rdata, 1);
    repeat (6) @(negedge clk); #1 chk("R4", "held high counts once", rdata, 1);
    ext = 1'b0; repeat (4) @(negedge clk);
    bus_wr(2'd2, 8'h00);
  endtask

  task automatic t_overflow();
    logic [15:0] c; logic [7:0] v;
    bus_wr(2'd2, 8'h00); load(16'hFFFE);
    bus_wr(2'd2, 8'h01);
    repeat (20) @(negedge clk);
    bus_wr(2'd2, 8'h00);
    chk("R6", "flag after wrap", flag, 1);
    snap(c); chk("R6", "count wrapped low", (c < 16'h0010) ? 1 : 0, 1);
    bus_wr(2'd3, 8'h00); chk("R7", "write 0 keeps flag", flag, 1);
    bus_wr(2'd3, 8'h01); peek(2'd3, v); chk("R7", "write 1 clears flag", v, 8'h00);
  endtask

  task automatic t_collision();
    logic [7:0] v;
    bus_wr(2'd2, 8'h00); load(16'hFFFF);
    bus_wr(2'd2, 8'h07);
    repeat (4) @(negedge clk);
    @(negedge clk); ext = 1'b1;
    bus_wr(2'd3, 8'h01);
    chk("R7", "flag survives clear on overflow edge", flag, 1);
    peek(2'd0, v); chk("R6", "low byte after wrap", v, 8'h00);
    ext = 1'b0; repeat (4) @(negedge clk);
    bus_wr(2'd2, 8'h00);
    bus_wr(2'd3, 8'h01); chk("R7", "later clear works", flag, 0);
  endtask

  task automatic t_evt_clear();
    logic [15:0] c;
    bus_wr(2'd2, 8'h00); load(16'h5555);
    @(negedge clk); evt = 1'b1;
    @(negedge clk); evt = 1'b0;
    snap(c); chk("R8", "trigger clears count", c, 16'h0000);
    load(16'h5555); bus_wr(2'd1, 8'h77);
    @(negedge clk); evt = 1'b1; wr = 1'b1; addr = 2'd0; wdata = 8'h11;
    @(negedge clk); evt = 1'b0; wr = 1'b0;
    snap(c); chk("R8", "trigger beats low write", c, 16'h0000);
    bus_wr(2'd2, 8'h01);
    @(negedge clk); evt = 1'b1; addr = 2'd0;
    repeat (9) @(negedge clk);
    #1 chk("R8", "trigger beats increment", rdata, 0);
    evt = 1'b0;
    bus_wr(2'd2, 8'h00);
  endtask

  task automatic t_coherent();
    logic [7:0] lo, hi; logic [15:0] c;
    bus_wr(2'd2, 8'h00); load(16'h00FD);
    bus_wr(2'd2, 8'h01);
    @(negedge clk); rd = 1'b1; addr = 2'd0; #1 lo = rdata;
    @(negedge clk); rd = 1'b0;
    repeat (40) @(negedge clk);
    addr = 2'd1; #1 hi = rdata;
    chk("R9", "low at capture", (lo == 8'hFD || lo == 8'hFE) ? 1 : 0, 1);
    chk("R9", "buffered high after low carry", hi, 8'h00);
    snap(c); chk("R9", "fresh high byte", c[15:8], 8'h01);
    bus_wr(2'd2, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ctrl_readback();
    t_write_staging();
    t_disabled();
    t_internal_rate(2'd0, 400);
    t_internal_rate(2'd1, 160);
    t_internal_rate(2'd3, 320);
    t_external_count();
    t_presc_clear();
    t_latency(1'b0);
    t_latency(1'b1);
    t_overflow();
    t_collision();
    t_evt_clear();
    t_coherent();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule